// File: doc/BRIEF.md
# Linear CCD Drive Clock Sequencer

This block produces every drive clock a two-output linear CCD sensor needs, all derived from one master clock. The outputs are the transfer gate pulse, the complementary shift pair `phi1`/`phi2`, a separately registered copy of `phi2` for the last register stage (`phi2l`), the reset gate pulse and the clamp pulse. It also produces a line-start strobe and a pixel-valid strobe for the capture logic. Each line begins with a guarded transfer-gate window and is followed by a fixed number of pixel periods. Each pixel period is one full `phi1`/`phi2` cycle and shifts out one odd and one even element. Every width and spacing is a whole number of master-clock cycles set by a parameter. Elaboration stops with an error when a setting falls outside the sensor's timing windows, which are a transfer gate of 1000 to 1500 ns, a guard of 200 to 300 ns, a reset pulse of 10 to 125 ns, a reset-to-clamp gap of at most 125 ns, a clamp pulse of 5 to 125 ns, and at most 22 MHz per output.

The sequencer is a five-state machine. ST_IDLE holds the idle levels. When `run` is high it takes IDLE_TO_PRE. ST_PRE is the leading guard, which lasts the guard count minus half a pixel period. It takes PRE_TO_XFER. ST_XFER holds the transfer gate high and takes XFER_TO_POST. ST_POST is the trailing guard and takes POST_TO_SHIFT. ST_SHIFT runs the pixel periods. At the end of the last period it takes SHIFT_TO_PRE when `run` is still high, or SHIFT_TO_IDLE when it is low. The line elements are ordered as leading elements, optical black, invalid, active, invalid and trailing elements.

Every output comes from a register, so each output shows the machine state one master cycle later. In bit-clamp mode the clamp pulse follows the reset pulse in every pixel period. In line-clamp mode the clamp is held high only across the optical-black periods.

Top module: `ccd_line_timer`

## Requirements
- R1: While `rst` is high, and in idle after it, the outputs are `tg`=0, `phi1`=1, `phi2`=0, `phi2l`=0, `rgate`=0, `clamp`=0, `line_start`=0 and `pix_valid`=0. No line starts while `run` stays low.
- R2: `line_start` is a one-cycle pulse in the first output cycle of a line. In that cycle `tg` is low and `phi1` is high.
- R3: In each line, `tg` is high for exactly TG_CYC consecutive cycles. It rises GUARD_CYC - PIX_CYC/2 cycles after `line_start`.
- R4: `phi1` stays high from GUARD_CYC cycles before the `tg` rise (measured from its last rise when lines run back to back) until GUARD_CYC cycles after the `tg` fall, and then it falls.
- R5: `phi2` is always the inverse of `phi1`, and `phi2l` always equals `phi2`.
- R6: After the transfer window there are (LEAD_N+OBLK_N+2*INV_N+VALID_N+TRAIL_N)/2 pixel periods of PIX_CYC cycles each. In each period `phi1` is low for the first PIX_CYC/2 cycles and high for the rest.
- R7: `rgate` is high for the first RG_CYC cycles of every pixel period. `rgate` and `clamp` are both low throughout the transfer-gate window and the guard phases.
- R8: In bit-clamp mode (`clamp_mode`=0), `clamp` is high for CP_CYC cycles that begin RG_CYC+CP_GAP_CYC cycles into every pixel period.
- R9: In line-clamp mode (`clamp_mode`=1), `clamp` is high in every cycle of the pixel periods whose element pair lies in the optical-black region, and low in all other cycles.
- R10: `clamp_mode` is sampled only when a line starts. A change during a line affects only the next line.
- R11: `pix_valid` is a one-cycle pulse in the first cycle of each pixel period whose element pair lies in the active region. This gives VALID_N/2 pulses per line.
- R12: When `run` is high at the end of a line, the next line starts in the following cycle. When `run` is low at that point, the block returns to the idle levels of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start lines, and keep starting them back to back |
| clamp_mode | input | 1 | 0 = clamp every pixel, 1 = clamp across the optical-black region only |
| tg | output | 1 | Transfer gate pulse |
| phi1 | output | 1 | Shift clock 1 |
| phi2 | output | 1 | Shift clock 2, the inverse of phi1 |
| phi2l | output | 1 | Last-stage shift clock, follows phi2 |
| rgate | output | 1 | Reset gate pulse |
| clamp | output | 1 | Clamp pulse |
| line_start | output | 1 | First output cycle of a line |
| pix_valid | output | 1 | First cycle of each active pixel period |

## Verification
Two situations are hard to reach from the ports. The first is a mode change that lands in the middle of a running line. The second is the join between two back-to-back lines, where the tail of the last pixel period must lead directly into the next guard.

To reach them, the stimulus keeps `run` high over three lines and flips `clamp_mode` right after each `line_start`. It then drops `run` during the third line so that SHIFT_TO_IDLE is taken. A fourth, isolated line in line-clamp mode follows. The scoreboard holds a cycle-exact expected vector for every output cycle of each line. It also expects the idle vector everywhere else, so a line that starts early or late, or a mode that is latched early, appears as a miscompare.

// File: rtl/ccd_line_timer_pkg.sv
package ccd_line_timer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_XFER,
        ST_POST,
        ST_SHIFT
    } seq_state_t;

    typedef enum logic [2:0] {
        RG_LEAD,
        RG_OBLK,
        RG_INV_A,
        RG_ACTIVE,
        RG_INV_B,
        RG_TRAIL
    } region_t;

    typedef struct packed {
        logic line_start;
        logic pix_valid;
        logic tg;
        logic phi1;
        logic phi2;
        logic phi2l;
        logic rgate;
        logic clamp;
    } drive_t;

    localparam drive_t DRIVE_IDLE = '{line_start: 1'b0, pix_valid: 1'b0, tg: 1'b0,
                                      phi1: 1'b1, phi2: 1'b0, phi2l: 1'b0,
                                      rgate: 1'b0, clamp: 1'b0};

endpackage

// File: rtl/ccd_seq_fsm.sv
module ccd_seq_fsm
    import ccd_line_timer_pkg::*;
#(
    parameter int unsigned PRE_CYC   = 21,
    parameter int unsigned TG_CYC    = 120,
    parameter int unsigned GUARD_CYC = 25,
    parameter int unsigned PIX_CYC   = 8,
    parameter int unsigned NPER      = 3771,
    parameter int unsigned CW        = 8,
    parameter int unsigned SW        = 4,
    parameter int unsigned PW        = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clamp_mode,
    output seq_state_t    state,
    output logic [CW-1:0] cnt,
    output logic [SW-1:0] sub,
    output logic [PW-1:0] per,
    output logic          mode_q
);

    localparam logic [CW-1:0] PRE_LAST   = CW'(PRE_CYC - 1);
    localparam logic [CW-1:0] XFER_LAST  = CW'(TG_CYC - 1);
    localparam logic [CW-1:0] POST_LAST  = CW'(GUARD_CYC - 1);
    localparam logic [SW-1:0] SUB_LAST   = SW'(PIX_CYC - 1);
    localparam logic [PW-1:0] PER_LAST   = PW'(NPER - 1);

    seq_state_t nxt;
    logic       period_end;
    logic       line_end;

    assign period_end = (sub == SUB_LAST);
    assign line_end   = period_end && (per == PER_LAST);

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (run)               nxt = ST_PRE;   // IDLE_TO_PRE
            ST_PRE:   if (cnt == PRE_LAST)   nxt = ST_XFER;  // PRE_TO_XFER
            ST_XFER:  if (cnt == XFER_LAST)  nxt = ST_POST;  // XFER_TO_POST
            ST_POST:  if (cnt == POST_LAST)  nxt = ST_SHIFT; // POST_TO_SHIFT
            ST_SHIFT: if (line_end)          nxt = run ? ST_PRE : ST_IDLE; // SHIFT_TO_PRE / SHIFT_TO_IDLE
            default:                         nxt = ST_IDLE;
        endcase
    end

    // state register and phase counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sub    <= '0;
            per    <= '0;
            mode_q <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                cnt <= '0;
            end else if (state == ST_PRE || state == ST_XFER || state == ST_POST) begin
                cnt <= cnt + 1'b1;
            end
            if (nxt == ST_SHIFT && state != ST_SHIFT) begin
                sub <= '0;
                per <= '0;
            end else if (state == ST_SHIFT) begin
                sub <= period_end ? '0 : sub + 1'b1;
                if (period_end) per <= per + 1'b1;
            end
            if (nxt == ST_PRE && state != ST_PRE) begin
                mode_q <= clamp_mode;
            end
        end
    end

endmodule

// File: rtl/ccd_region_map.sv
module ccd_region_map
    import ccd_line_timer_pkg::*;
#(
    parameter int unsigned LEAD_N  = 28,
    parameter int unsigned OBLK_N  = 96,
    parameter int unsigned INV_N   = 6,
    parameter int unsigned VALID_N = 7400,
    parameter int unsigned PW      = 12
) (
    input  logic [PW-1:0] per,
    output region_t       region
);

    // region boundaries in pixel periods (two elements per period)
    localparam int unsigned NB = 5;
    localparam int unsigned B_LEAD  = LEAD_N / 2;
    localparam int unsigned B_OBLK  = B_LEAD + OBLK_N / 2;
    localparam int unsigned B_INVA  = B_OBLK + INV_N / 2;
    localparam int unsigned B_ACT   = B_INVA + VALID_N / 2;
    localparam int unsigned B_INVB  = B_ACT + INV_N / 2;

    logic [NB-1:0] below;

    for (genvar i = 0; i < NB; i++) begin : g_bound
        localparam int unsigned LIM = (i == 0) ? B_LEAD :
                                      (i == 1) ? B_OBLK :
                                      (i == 2) ? B_INVA :
                                      (i == 3) ? B_ACT  : B_INVB;
        assign below[i] = (per < PW'(LIM));
    end

    always_comb begin
        if      (below[0]) region = RG_LEAD;
        else if (below[1]) region = RG_OBLK;
        else if (below[2]) region = RG_INV_A;
        else if (below[3]) region = RG_ACTIVE;
        else if (below[4]) region = RG_INV_B;
        else               region = RG_TRAIL;
    end

endmodule

// File: rtl/ccd_drive_dec.sv
module ccd_drive_dec
    import ccd_line_timer_pkg::*;
#(
    parameter int unsigned PIX_CYC    = 8,
    parameter int unsigned RG_CYC     = 2,
    parameter int unsigned CP_GAP_CYC = 1,
    parameter int unsigned CP_CYC     = 2,
    parameter int unsigned CW         = 8,
    parameter int unsigned SW         = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_state_t    state,
    input  logic [CW-1:0] cnt,
    input  logic [SW-1:0] sub,
    input  region_t       region,
    input  logic          mode_q,
    output drive_t        drv
);

    localparam logic [SW-1:0] HALF   = SW'(PIX_CYC / 2);
    localparam logic [SW-1:0] RG_END = SW'(RG_CYC);
    localparam logic [SW-1:0] CP_ON  = SW'(RG_CYC + CP_GAP_CYC);
    localparam logic [SW-1:0] CP_OFF = SW'(RG_CYC + CP_GAP_CYC + CP_CYC);

    drive_t nxt;

    // output decode
    always_comb begin
        nxt = DRIVE_IDLE;
        unique case (state)
            ST_IDLE:  ;
            ST_PRE:   nxt.line_start = (cnt == '0);
            ST_XFER:  nxt.tg = 1'b1;
            ST_POST:  ;
            ST_SHIFT: begin
                nxt.phi1      = (sub >= HALF);
                nxt.rgate     = (sub < RG_END);
                nxt.clamp     = mode_q ? (region == RG_OBLK)
                                       : (sub >= CP_ON && sub < CP_OFF);
                nxt.pix_valid = (region == RG_ACTIVE) && (sub == '0);
            end
            default:  ;
        endcase
        nxt.phi2  = !nxt.phi1;
        nxt.phi2l = !nxt.phi1;
    end

    always_ff @(posedge clk) begin
        if (rst) drv <= DRIVE_IDLE;
        else     drv <= nxt;
    end

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
    import ccd_line_timer_pkg::*;
#(
    parameter int unsigned CLK_NS     = 10,
    parameter int unsigned PIX_CYC    = 8,
    parameter int unsigned TG_CYC     = 120,
    parameter int unsigned GUARD_CYC  = 25,
    parameter int unsigned RG_CYC     = 2,
    parameter int unsigned CP_GAP_CYC = 1,
    parameter int unsigned CP_CYC     = 2,
    parameter int unsigned LEAD_N     = 28,
    parameter int unsigned OBLK_N     = 96,
    parameter int unsigned INV_N      = 6,
    parameter int unsigned VALID_N    = 7400,
    parameter int unsigned TRAIL_N    = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clamp_mode,
    output logic tg,
    output logic phi1,
    output logic phi2,
    output logic phi2l,
    output logic rgate,
    output logic clamp,
    output logic line_start,
    output logic pix_valid
);

    localparam int unsigned ELEM_N  = LEAD_N + OBLK_N + 2 * INV_N + VALID_N + TRAIL_N;
    localparam int unsigned NPER    = ELEM_N / 2;
    localparam int unsigned HALF    = PIX_CYC / 2;
    localparam int unsigned PRE_CYC = GUARD_CYC - HALF;
    localparam int unsigned CW      = $clog2(TG_CYC + GUARD_CYC + 1);
    localparam int unsigned SW      = $clog2(PIX_CYC + 1);
    localparam int unsigned PW      = $clog2(NPER + 1);

    // elaboration-time timing window checks
    if (TG_CYC * CLK_NS < 1000 || TG_CYC * CLK_NS > 1500) begin : g_bad_tg
        $error("transfer gate width outside 1000..1500 ns");
    end
    if (GUARD_CYC * CLK_NS < 200 || GUARD_CYC * CLK_NS > 300) begin : g_bad_guard
        $error("transfer gate guard outside 200..300 ns");
    end
    if (RG_CYC * CLK_NS < 10 || RG_CYC * CLK_NS > 125) begin : g_bad_rg
        $error("reset gate width outside 10..125 ns");
    end
    if (CP_GAP_CYC * CLK_NS > 125) begin : g_bad_gap
        $error("reset-to-clamp gap above 125 ns");
    end
    if (CP_CYC * CLK_NS < 5 || CP_CYC * CLK_NS > 125) begin : g_bad_cp
        $error("clamp width outside 5..125 ns");
    end
    if (PIX_CYC * CLK_NS * 22 < 1000) begin : g_bad_rate
        $error("pixel rate per output above 22 MHz");
    end
    if (PIX_CYC % 2 != 0 || RG_CYC + CP_GAP_CYC + CP_CYC > PIX_CYC) begin : g_bad_pix
        $error("pixel period must be even and hold reset and clamp");
    end
    if (GUARD_CYC <= HALF) begin : g_bad_pre
        $error("guard must exceed half a pixel period");
    end
    if (LEAD_N % 2 != 0 || OBLK_N % 2 != 0 || INV_N % 2 != 0 ||
        VALID_N % 2 != 0 || TRAIL_N % 2 != 0) begin : g_bad_elem
        $error("element region counts must be even");
    end

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic [SW-1:0] sub;
    logic [PW-1:0] per;
    logic          mode_q;
    region_t       region;
    drive_t        drv;

    ccd_seq_fsm #(
        .PRE_CYC  (PRE_CYC),
        .TG_CYC   (TG_CYC),
        .GUARD_CYC(GUARD_CYC),
        .PIX_CYC  (PIX_CYC),
        .NPER     (NPER),
        .CW       (CW),
        .SW       (SW),
        .PW       (PW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .clamp_mode(clamp_mode),
        .state     (state),
        .cnt       (cnt),
        .sub       (sub),
        .per       (per),
        .mode_q    (mode_q)
    );

    ccd_region_map #(
        .LEAD_N (LEAD_N),
        .OBLK_N (OBLK_N),
        .INV_N  (INV_N),
        .VALID_N(VALID_N),
        .PW     (PW)
    ) u_region (
        .per   (per),
        .region(region)
    );

    ccd_drive_dec #(
        .PIX_CYC   (PIX_CYC),
        .RG_CYC    (RG_CYC),
        .CP_GAP_CYC(CP_GAP_CYC),
        .CP_CYC    (CP_CYC),
        .CW        (CW),
        .SW        (SW)
    ) u_dec (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .cnt   (cnt),
        .sub   (sub),
        .region(region),
        .mode_q(mode_q),
        .drv   (drv)
    );

    assign tg         = drv.tg;
    assign phi1       = drv.phi1;
    assign phi2       = drv.phi2;
    assign phi2l      = drv.phi2l;
    assign rgate      = drv.rgate;
    assign clamp      = drv.clamp;
    assign line_start = drv.line_start;
    assign pix_valid  = drv.pix_valid;

endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
    parameter int unsigned TG_CYC    = 120,
    parameter int unsigned GUARD_CYC = 25
) (
    input logic clk,
    input logic rst,
    input logic tg,
    input logic phi1,
    input logic phi2,
    input logic phi2l,
    input logic rgate,
    input logic clamp,
    input logic line_start,
    input logic pix_valid
);

    logic [15:0] tg_run;
    logic [15:0] phi1_hold;
    logic        phi1_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            tg_run    <= '0;
            phi1_hold <= '0;
            phi1_d    <= 1'b1;
        end else begin
            tg_run <= tg ? tg_run + 1'b1 : '0;
            phi1_d <= phi1;
            if (phi1 != phi1_d)        phi1_hold <= '0;
            else if (phi1_hold != '1)  phi1_hold <= phi1_hold + 1'b1;
        end
    end

    // R3
    tg_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tg) |-> (tg_run == 16'(TG_CYC)));

    // R4
    tg_lead_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tg) |-> (phi1_hold >= 16'(GUARD_CYC - 1)));

    // R4
    tg_phi1_high_chk: assert property (@(posedge clk) disable iff (rst)
        tg |-> phi1);

    // R5
    phi_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (phi1 ^ phi2) && (phi2l == phi2));

    // R7
    no_gate_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        tg |-> (!rgate && !clamp));

    // R11
    pix_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> !pix_valid);

    // R2
    line_start_chk: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (!tg && phi1 && !rgate && !clamp));

endmodule

bind ccd_line_timer ccd_line_timer_chk #(
    .TG_CYC   (TG_CYC),
    .GUARD_CYC(GUARD_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tg        (tg),
    .phi1      (phi1),
    .phi2      (phi2),
    .phi2l     (phi2l),
    .rgate     (rgate),
    .clamp     (clamp),
    .line_start(line_start),
    .pix_valid (pix_valid)
);

// File: tb/test_ccd_line_timer.sv
module test_ccd_line_timer;

    localparam int PIX   = 8;
    localparam int TGC   = 120;
    localparam int GRD   = 25;
    localparam int RGC   = 2;
    localparam int GAP   = 1;
    localparam int CPC   = 2;
    localparam int LEAD  = 4;
    localparam int OBLK  = 4;
    localparam int INV   = 2;
    localparam int VALID = 8;
    localparam int TRAIL = 2;
    localparam int NPER  = (LEAD + OBLK + 2 * INV + VALID + TRAIL) / 2;
    localparam int PRE   = GRD - PIX / 2;
    localparam int SHIFT0 = PRE + TGC + GRD;
    localparam int LINE_LEN = SHIFT0 + NPER * PIX;
    localparam logic [7:0] IDLE_VEC = 8'b0001_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic clamp_mode = 1'b0;
    logic tg, phi1, phi2, phi2l, rgate, clamp, line_start, pix_valid;

    always #5 clk = ~clk;

    ccd_line_timer #(
        .CLK_NS(10), .PIX_CYC(PIX), .TG_CYC(TGC), .GUARD_CYC(GRD),
        .RG_CYC(RGC), .CP_GAP_CYC(GAP), .CP_CYC(CPC),
        .LEAD_N(LEAD), .OBLK_N(OBLK), .INV_N(INV), .VALID_N(VALID), .TRAIL_N(TRAIL)
    ) i_ccd_line_timer (
        .clk(clk), .rst(rst), .run(run), .clamp_mode(clamp_mode),
        .tg(tg), .phi1(phi1), .phi2(phi2), .phi2l(phi2l), .rgate(rgate),
        .clamp(clamp), .line_start(line_start), .pix_valid(pix_valid)
    );

    typedef struct {
        logic [7:0] v;
        int         j;
        bit         m;
        bit         chg;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    bit   seen_line = 1'b0;

    // expected output vector {ls,pv,tg,phi1,phi2,phi2l,rg,cp} for cycle j of a line
    function automatic logic [7:0] model(int j, bit m);
        logic ls, pv, t, p1, rg, cp;
        int s, p, u, e;
        ls = (j == 0); pv = 0; t = 0; p1 = 1; rg = 0; cp = 0;
        if (j >= PRE && j < PRE + TGC) t = 1;
        if (j >= SHIFT0) begin
            s = j - SHIFT0; p = s / PIX; u = s % PIX; e = 2 * p;
            p1 = (u >= PIX / 2);
            rg = (u < RGC);
            if (m) cp = (e >= LEAD && e < LEAD + OBLK);
            else   cp = (u >= RGC + GAP && u < RGC + GAP + CPC);
            pv = (e >= LEAD + OBLK + INV && e < LEAD + OBLK + INV + VALID) && (u == 0);
        end
        return {ls, pv, t, p1, !p1, !p1, rg, cp};
    endfunction

    function automatic string tag_of(logic [7:0] d, int j, bit m, bit chg);
        if (d[7]) return "R2";
        if (d[6]) return "R11";
        if (d[5]) return "R3";
        if (d[4]) return (j < SHIFT0) ? "R4" : "R6";
        if (d[3] || d[2]) return "R5";
        if (d[1]) return "R7";
        if (d[0]) return chg ? "R10" : (m ? "R9" : "R8");
        return "R6";
    endfunction

    bit last_mode = 1'b0;
    bit first_push = 1'b1;

    task automatic push_line(bit m);
        for (int j = 0; j < LINE_LEN; j++) begin
            exp_t e;
            e.v = model(j, m); e.j = j; e.m = m;
            e.chg = !first_push && (m != last_mode);
            exp_q.push_back(e);
        end
        first_push = 1'b0;
        last_mode = m;
    endtask

    task automatic wait_ls();
        do @(negedge clk); while (line_start !== 1'b1);
    endtask

    task automatic wait_drain(int extra);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (extra) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        bit active = 1'b0;
        logic [7:0] act;
        forever begin
            @(negedge clk);
            if (!done) begin
                act = {line_start, pix_valid, tg, phi1, phi2, phi2l, rgate, clamp};
                if (!active && line_start === 1'b1 && exp_q.size() != 0) active = 1'b1;
                n_chk++;
                if (active) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (act !== e.v) begin
                        n_bad++;
                        $display("FAIL %s line cycle %0d: actual=%b expected=%b",
                                 tag_of(act ^ e.v, e.j, e.m, e.chg), e.j, act, e.v);
                    end
                    if (exp_q.size() == 0) begin
                        active = 1'b0;
                        seen_line = 1'b1;
                    end
                end else if (act !== IDLE_VEC) begin
                    n_bad++;
                    $display("FAIL %s idle: actual=%b expected=%b",
                             seen_line ? "R12" : "R1", act, IDLE_VEC);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // driver
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;                           // R1: reset and idle levels checked
        repeat (12) @(negedge clk);           // R1: no line while run low
        clamp_mode = 1'b0;
        push_line(1'b0);                      // line 1: bit clamp R8
        run = 1'b1;
        wait_ls();
        clamp_mode = 1'b1;                    // R10: mid-line change, next line only
        push_line(1'b1);                      // line 2: line clamp R9, back to back R12
        wait_ls();
        clamp_mode = 1'b0;
        push_line(1'b0);                      // line 3
        wait_ls();
        run = 1'b0;                           // R12: return to idle after line 3
        wait_drain(20);
        clamp_mode = 1'b1;
        push_line(1'b1);                      // line 4: isolated, line clamp
        run = 1'b1;
        wait_ls();
        run = 1'b0;
        clamp_mode = 1'b0;
        wait_drain(10);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule